// File: doc/BRIEF.md
# Timestamp and Pulse Timer Generator

This block provides the time base for a packet-processing engine. It runs on a 19.2 MHz reference clock. A free-running 56-bit counter advances on every reference cycle and is exported as a whole. Three 32-bit coarse timestamps are cut from it at programmable bit positions: one for tagging, one for address-translation entries and one for data-path logging. The logging stamp can instead carry a legacy millisecond count. Each coarser stamp is a right shift of the base count, so a shift of 14 gives a step of roughly 853 µs and a shift of 24 gives roughly 874 ms.

A programmable divider turns the reference clock into a common timer tick. The divider value holds the ratio minus one, so 191 yields a 100 kHz tick. Three pulse generators count these ticks and each emits a one-cycle pulse at its own selected granularity. Downstream timers, such as aggregation and head-of-line timeouts, use these pulses as their time unit. The block is configured through a small write-only register port. Because the divider value may only change while the divider is switched off, software first disables the divider, then writes the new ratio, then enables it in a separate write.

Top module: `tstick_gen`

## Requirements
- R1: After reset the 56-bit base count `ts_base` is 0 and it increases by exactly 1 on every clock edge, regardless of any configuration.
- R2: `ts_tag` and `ts_nat` equal bits [s+31:s] of the base count, where s is the corresponding shift field. Positions above bit 55 read as 0, and a shift of 0 gives the low 32 bits.
- R3: With the log select bit at 1, `ts_log` is the base count shifted by the log shift field. With the bit at 0, `ts_log` is a legacy count that increases once every LEGACY_CYC clocks since reset, so it equals `ts_base / LEGACY_CYC`.
- R4: With divider value V and enable 1, `timer_tick` is high for one cycle in every V+1. The first tick comes in cycle V counted from 0, where cycle 0 is the first cycle after the enabling write.
- R5: Each pulse output is high only together with `timer_tick`, on every L-th tick counted from enable. Granularity code 0..7 selects L = 1, 2, 5, 10, 100, 1000, 10000, 65535, which at a 100 kHz tick is 10 µs, 20 µs, 50 µs, 100 µs, 1 ms, 10 ms, 100 ms and 655.35 ms.
- R6: While the divider enable is 0, `timer_tick` and all pulses stay low and the divider and pulse counters are cleared. Re-enabling therefore restarts the phase as in R4, and the base count keeps running.
- R7: A divider write made while the enable is 1 leaves the divider value unchanged; only its enable bit takes effect.
- R8: Register writes take effect on the clock edge that samples `cfg_we`. Address 0 holds the tag shift in [5:0], the NAT shift in [13:8], the log shift in [21:16] and the log select in [24]. Address 1 holds the granularity of generator i in bits [4i+2:4i]. Address 2 holds the divider value in [15:0] and the enable in [31]. Writes to address 3 change nothing.
- R9: Reset clears all shift fields, the log select, the granularities, the divider value and the divider enable, so every output reads 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 19.2 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| ts_base | output | CNT_W (56) | Free-running base count |
| ts_log | output | TS_W (32) | Logging timestamp (shifted or legacy ms count) |
| ts_tag | output | TS_W (32) | Tag timestamp |
| ts_nat | output | TS_W (32) | Address-translation timestamp |
| timer_tick | output | 1 | Common timer tick from the divider |
| pulse | output | NUM_PG (3) | One-cycle pulse per generator |

## Verification
The bench builds the block with LEGACY_CYC = 8, so the legacy millisecond path advances within tens of cycles and can be compared exactly against the base count. The other parameters keep their defaults. Divider values of 0, 1 and 3 are used so that each of the eight granularity codes, up to 65535 ticks, runs to completion and its first-pulse position and pulse count can be checked. Base counts in the hundreds of cycles make the non-zero shifted taps and the all-zero high positions observable.

// File: rtl/tstick_pkg.sv
`timescale 1ns/1ps
package tstick_pkg;

    localparam int SHIFT_W = 6;
    localparam int GRAN_W  = 3;
    localparam int PCNT_W  = 16;

    typedef enum logic [GRAN_W-1:0] {
        GRAN_10US  = 3'd0,
        GRAN_20US  = 3'd1,
        GRAN_50US  = 3'd2,
        GRAN_100US = 3'd3,
        GRAN_1MS   = 3'd4,
        GRAN_10MS  = 3'd5,
        GRAN_100MS = 3'd6,
        GRAN_LONG  = 3'd7
    } gran_e;

    // number of common ticks per pulse for each granularity code
    function automatic logic [PCNT_W-1:0] gran_ticks(input logic [GRAN_W-1:0] g);
        logic [PCNT_W-1:0] n;
        case (gran_e'(g))
            GRAN_10US:  n = 16'd1;
            GRAN_20US:  n = 16'd2;
            GRAN_50US:  n = 16'd5;
            GRAN_100US: n = 16'd10;
            GRAN_1MS:   n = 16'd100;
            GRAN_10MS:  n = 16'd1000;
            GRAN_100MS: n = 16'd10000;
            default:    n = 16'd65535;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tstick_regs.sv
`timescale 1ns/1ps
module tstick_regs
    import tstick_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int NUM_PG = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [1:0]                       addr,
    input  logic [31:0]                      wdata,
    output logic [SHIFT_W-1:0]               tag_shift,
    output logic [SHIFT_W-1:0]               nat_shift,
    output logic [SHIFT_W-1:0]               log_shift,
    output logic                             log_sel,
    output logic [NUM_PG-1:0][GRAN_W-1:0]    gran,
    output logic [DIV_W-1:0]                 div_val,
    output logic                             div_en
);

    localparam int EN_BIT = 31;

    typedef struct packed {
        logic [SHIFT_W-1:0]            tag_shift;
        logic [SHIFT_W-1:0]            nat_shift;
        logic [SHIFT_W-1:0]            log_shift;
        logic                          log_sel;
        logic [NUM_PG-1:0][GRAN_W-1:0] gran;
        logic [DIV_W-1:0]              div_val;
        logic                          div_en;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                2'd0: begin
                    r_d.tag_shift = wdata[SHIFT_W-1:0];
                    r_d.nat_shift = wdata[8 +: SHIFT_W];
                    r_d.log_shift = wdata[16 +: SHIFT_W];
                    r_d.log_sel   = wdata[24];
                end
                2'd1: begin
                    for (int i = 0; i < NUM_PG; i++) begin
                        r_d.gran[i] = wdata[4*i +: GRAN_W];
                    end
                end
                2'd2: begin
                    // ratio is locked while the divider runs
                    if (!r_q.div_en) begin
                        r_d.div_val = wdata[DIV_W-1:0];
                    end
                    r_d.div_en = wdata[EN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tag_shift = r_q.tag_shift;
    assign nat_shift = r_q.nat_shift;
    assign log_shift = r_q.log_shift;
    assign log_sel   = r_q.log_sel;
    assign gran      = r_q.gran;
    assign div_val   = r_q.div_val;
    assign div_en    = r_q.div_en;

endmodule

// File: rtl/tstick_base.sv
`timescale 1ns/1ps
module tstick_base #(
    parameter int CNT_W      = 56,
    parameter int TS_W       = 32,
    parameter int LEGACY_CYC = 19200
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] base,
    output logic [TS_W-1:0]  ms_count
);

    localparam int LC_W = (LEGACY_CYC > 1) ? $clog2(LEGACY_CYC) : 1;
    localparam logic [LC_W-1:0] LC_LAST = LC_W'(LEGACY_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] base;
        logic [LC_W-1:0]  lcnt;
        logic [TS_W-1:0]  ms;
    } base_t;

    base_t b_d, b_q;

    always_comb begin
        b_d      = b_q;
        b_d.base = b_q.base + 1'b1;
        if (b_q.lcnt == LC_LAST) begin
            b_d.lcnt = '0;
            b_d.ms   = b_q.ms + 1'b1;
        end else begin
            b_d.lcnt = b_q.lcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign base     = b_q.base;
    assign ms_count = b_q.ms;

endmodule

// File: rtl/tstick_div.sv
`timescale 1ns/1ps
module tstick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] val,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t v_d, v_q;

    assign tick = en && (v_q.cnt == val);

    always_comb begin
        v_d = v_q;
        if (!en || tick) begin
            v_d.cnt = '0;
        end else begin
            v_d.cnt = v_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

endmodule

// File: rtl/tstick_pulse.sv
`timescale 1ns/1ps
module tstick_pulse
    import tstick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [GRAN_W-1:0] gran,
    output logic              pulse
);

    typedef struct packed {
        logic [PCNT_W-1:0] cnt;
    } pg_t;

    pg_t p_d, p_q;
    logic [PCNT_W-1:0] last;

    assign last  = gran_ticks(gran) - 1'b1;
    // >= keeps a generator from running away after a granularity cut
    assign pulse = en && tick && (p_q.cnt >= last);

    always_comb begin
        p_d = p_q;
        if (!en || pulse) begin
            p_d.cnt = '0;
        end else if (tick) begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/tstick_gen.sv
`timescale 1ns/1ps
module tstick_gen
    import tstick_pkg::*;
#(
    parameter int CNT_W      = 56,
    parameter int TS_W       = 32,
    parameter int DIV_W      = 16,
    parameter int NUM_PG     = 3,
    parameter int LEGACY_CYC = 19200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [CNT_W-1:0]  ts_base,
    output logic [TS_W-1:0]   ts_log,
    output logic [TS_W-1:0]   ts_tag,
    output logic [TS_W-1:0]   ts_nat,
    output logic              timer_tick,
    output logic [NUM_PG-1:0] pulse
);

    logic [SHIFT_W-1:0]            tag_shift_w, nat_shift_w, log_shift_w;
    logic                          log_sel_w;
    logic [NUM_PG-1:0][GRAN_W-1:0] gran_w;
    logic [DIV_W-1:0]              div_val_w;
    logic                          div_en_w;
    logic [CNT_W-1:0]              base_w;
    logic [TS_W-1:0]               ms_w;

    function automatic logic [TS_W-1:0] tap(input logic [CNT_W-1:0] b,
                                            input logic [SHIFT_W-1:0] sh);
        return TS_W'(b >> sh);
    endfunction

    tstick_regs #(.DIV_W(DIV_W), .NUM_PG(NUM_PG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .tag_shift (tag_shift_w),
        .nat_shift (nat_shift_w),
        .log_shift (log_shift_w),
        .log_sel   (log_sel_w),
        .gran      (gran_w),
        .div_val   (div_val_w),
        .div_en    (div_en_w)
    );

    tstick_base #(.CNT_W(CNT_W), .TS_W(TS_W), .LEGACY_CYC(LEGACY_CYC)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (base_w),
        .ms_count (ms_w)
    );

    tstick_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en_w),
        .val   (div_val_w),
        .tick  (timer_tick)
    );

    for (genvar g = 0; g < NUM_PG; g++) begin : g_pg
        tstick_pulse u_pg (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (div_en_w),
            .tick  (timer_tick),
            .gran  (gran_w[g]),
            .pulse (pulse[g])
        );
    end

    assign ts_base = base_w;
    assign ts_tag  = tap(base_w, tag_shift_w);
    assign ts_nat  = tap(base_w, nat_shift_w);
    assign ts_log  = log_sel_w ? tap(base_w, log_shift_w) : ms_w;

endmodule

// File: rtl/tstick_gen_chk.sv
`timescale 1ns/1ps
module tstick_gen_chk #(
    parameter int CNT_W  = 56,
    parameter int DIV_W  = 16,
    parameter int NUM_PG = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  base,
    input logic              tick,
    input logic [NUM_PG-1:0] pulse,
    input logic              div_en,
    input logic [DIV_W-1:0]  div_val
);

    // R1: base count advances by one every cycle
    a_r1_base_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (base == $past(base) + 1'b1));

    // R6: nothing ticks or pulses while the divider is off
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |-> (!tick && (pulse == '0)));

    // R5: a pulse only ever coincides with a common tick
    a_r5_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |-> tick);

    // R7: the divider ratio cannot move while enabled
    a_r7_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |=> $stable(div_val));

    // R4: ticks are separated when the ratio is above one
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_val != '0)) |=> !tick);

endmodule

bind tstick_gen tstick_gen_chk #(
    .CNT_W  (CNT_W),
    .DIV_W  (DIV_W),
    .NUM_PG (NUM_PG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .base    (ts_base),
    .tick    (timer_tick),
    .pulse   (pulse),
    .div_en  (div_en_w),
    .div_val (div_val_w)
);

// File: tb/tstick_gen_bench.sv
`timescale 1ns/1ps
module tstick_gen_bench;

    localparam int CNT_W  = 56;
    localparam int TS_W   = 32;
    localparam int DIV_W  = 16;
    localparam int NUM_PG = 3;
    localparam int LEG    = 8;

    logic              clk;
    logic              rst_n;
    logic              cfg_we;
    logic [1:0]        cfg_addr;
    logic [31:0]       cfg_wdata;
    logic [CNT_W-1:0]  ts_base;
    logic [TS_W-1:0]   ts_log, ts_tag, ts_nat;
    logic              timer_tick;
    logic [NUM_PG-1:0] pulse;

    tstick_gen #(
        .CNT_W(CNT_W), .TS_W(TS_W), .DIV_W(DIV_W),
        .NUM_PG(NUM_PG), .LEGACY_CYC(LEG)
    ) u_tstick_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ts_base(ts_base), .ts_log(ts_log),
        .ts_tag(ts_tag), .ts_nat(ts_nat), .timer_tick(timer_tick), .pulse(pulse)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    typedef struct {
        string   req;
        string   what;
        longint  act;
        longint  exp;
    } item_t;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;

    int w_ticks, w_first_tick;
    int w_pc[NUM_PG];
    int w_fp[NUM_PG];

    // driver side: queue an expectation with its observed value
    task automatic expect_eq(input string req, input string what,
                             input longint act, input longint exp);
        item_t it;
        it.req = req; it.what = what; it.act = act; it.exp = exp;
        sb_q.push_back(it);
    endtask

    // monitor: pops and compares
    initial begin
        item_t it;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            n_vec++;
            if (it.act != it.exp) begin
                n_bad++;
                $display("FAIL %s %s: actual %0d expected %0d",
                         it.req, it.what, it.act, it.exp);
            end
        end
    end

    initial begin
        #1900000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_window(input int n);
        w_ticks = 0; w_first_tick = -1;
        for (int p = 0; p < NUM_PG; p++) begin w_pc[p] = 0; w_fp[p] = -1; end
        for (int i = 0; i < n; i++) begin
            if (timer_tick) begin
                if (w_first_tick < 0) w_first_tick = i;
                w_ticks++;
            end
            for (int p = 0; p < NUM_PG; p++) begin
                if (pulse[p]) begin
                    if (w_fp[p] < 0) w_fp[p] = i;
                    w_pc[p]++;
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic tick_gap(output int g);
        int k;
        k = 0;
        while (!timer_tick && k < 100) begin @(negedge clk); k++; end
        g = 0;
        do begin @(negedge clk); g++; end while (!timer_tick && g < 100);
    endtask

    task automatic check_taps(input string req, input int tsh, input int nsh, input int lsh);
        longint unsigned b;
        b = longint'(ts_base);
        expect_eq(req, "ts_tag", longint'(ts_tag), longint'((b >> tsh) & 64'hFFFF_FFFF));
        expect_eq(req, "ts_nat", longint'(ts_nat), longint'((b >> nsh) & 64'hFFFF_FFFF));
        if (lsh >= 0)
            expect_eq("R3", "ts_log shifted", longint'(ts_log), longint'((b >> lsh) & 64'hFFFF_FFFF));
    endtask

    initial begin
        int g;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        expect_eq("R9", "ts_base in reset", longint'(ts_base), 0);
        expect_eq("R9", "ts_log in reset", longint'(ts_log), 0);
        expect_eq("R9", "ts_tag in reset", longint'(ts_tag), 0);
        expect_eq("R9", "tick/pulse in reset", longint'({timer_tick, pulse}), 0);
        rst_n = 1'b1;
        // R1: exact count since reset
        expect_eq("R1", "ts_base at release", longint'(ts_base), 0);
        repeat (10) @(negedge clk);
        expect_eq("R1", "ts_base after 10", longint'(ts_base), 10);
        // R3: legacy count, select defaults to 0
        expect_eq("R3", "legacy ms", longint'(ts_log), longint'(ts_base) / LEG);
        // R6: divider off, nothing ticks
        run_window(30);
        expect_eq("R6", "ticks while off", w_ticks, 0);
        expect_eq("R6", "pulses while off", w_pc[0] + w_pc[1] + w_pc[2], 0);
        // R8 / R2: program shifts, tag=3 nat=7 log=2 select=1
        wr(2'd0, 32'h0102_0703);
        check_taps("R2", 3, 7, 2);
        repeat (300) @(negedge clk);
        check_taps("R2", 3, 7, 2);
        // R2: high position reads zero, shift 0 gives low bits
        wr(2'd0, 32'h0100_0028);
        expect_eq("R2", "ts_tag shift 40", longint'(ts_tag), 0);
        check_taps("R2", 40, 0, -1);
        // R8: address 3 ignored
        wr(2'd3, 32'hFFFF_FFFF);
        check_taps("R8", 40, 0, -1);
        run_window(20);
        expect_eq("R8", "no tick after addr3 write", w_ticks, 0);
        // R3: back to legacy count
        wr(2'd0, 32'h0000_0000);
        expect_eq("R3", "legacy ms later", longint'(ts_log), longint'(ts_base) / LEG);
        // R4 / R5: ratio 4, gran codes 0,1,2
        wr(2'd2, 32'h0000_0003);
        wr(2'd1, 32'h0000_0210);
        wr(2'd2, 32'h8000_0003);
        run_window(40);
        expect_eq("R4", "tick count /4", w_ticks, 10);
        expect_eq("R4", "first tick /4", w_first_tick, 3);
        expect_eq("R5", "pg0 gran0 count", w_pc[0], 10);
        expect_eq("R5", "pg1 gran1 count", w_pc[1], 5);
        expect_eq("R5", "pg2 gran2 count", w_pc[2], 2);
        expect_eq("R5", "pg2 gran2 first", w_fp[2], 19);
        // R7: ratio write while enabled ignored
        wr(2'd2, 32'h8000_0001);
        tick_gap(g);
        expect_eq("R7", "tick gap after locked write", g, 4);
        // R6: disable stops everything at once
        wr(2'd2, 32'h0000_0000);
        expect_eq("R6", "tick/pulse after disable", longint'({timer_tick, pulse}), 0);
        run_window(20);
        expect_eq("R6", "ticks after disable", w_ticks, 0);
        expect_eq("R6", "base runs while off", longint'(ts_base) > 0 ? 1 : 0, 1);
        wr(2'd2, 32'h8000_0003);
        run_window(8);
        expect_eq("R6", "restart first tick", w_first_tick, 3);
        // R5: ratio 1, codes 3,4,1
        wr(2'd2, 32'h0000_0000);
        wr(2'd2, 32'h0000_0000);
        wr(2'd1, 32'h0000_0143);
        wr(2'd2, 32'h8000_0000);
        run_window(200);
        expect_eq("R4", "tick every cycle", w_ticks, 200);
        expect_eq("R4", "first tick ratio1", w_first_tick, 0);
        expect_eq("R5", "pg0 gran3 count", w_pc[0], 20);
        expect_eq("R5", "pg0 gran3 first", w_fp[0], 9);
        expect_eq("R5", "pg1 gran4 count", w_pc[1], 2);
        expect_eq("R5", "pg1 gran4 first", w_fp[1], 99);
        expect_eq("R5", "pg2 gran1 count", w_pc[2], 100);
        expect_eq("R5", "pg2 gran1 first", w_fp[2], 1);
        // R5: long codes 6,7,5
        wr(2'd2, 32'h0000_0000);
        wr(2'd1, 32'h0000_0576);
        wr(2'd2, 32'h8000_0000);
        run_window(65535);
        expect_eq("R5", "pg0 gran6 count", w_pc[0], 6);
        expect_eq("R5", "pg0 gran6 first", w_fp[0], 9999);
        expect_eq("R5", "pg1 gran7 count", w_pc[1], 1);
        expect_eq("R5", "pg1 gran7 first", w_fp[1], 65534);
        expect_eq("R5", "pg2 gran5 count", w_pc[2], 65);
        expect_eq("R5", "pg2 gran5 first", w_fp[2], 999);
        done = 1;
        wait (sb_q.size() == 0);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule